// File: doc/BRIEF.md
# Segment Attribute Register Bank

This block keeps one 32-bit attribute word for every 16 MB slice of a 32-bit address space, 256 words in all. Each word carries two live flags: one says whether accesses to that slice may be held in a cache, the other whether a prefetcher may fetch ahead inside it. Every other bit of the word is tied to zero. The sixteen lowest slices cover on-chip memory and their words are fixed: software can read them but cannot change them.

Software reaches the words through a simple register port: a byte address whose bits [9:2] pick the word, a write strobe with write data, and read data that follows the address in the same cycle. Memory-side logic uses the second port: it presents a full access address, the slice is chosen by the top eight address bits, and the two flags for that slice come back one clock later together with a valid strobe.

Top module: `segattr_bank`

## Requirements
- R1: After reset every word reads as 0x0000_0000 and every lookup returns both flags low.
- R2: A write to a word whose index cfg_addr[9:2] is 16 or above takes bit 0 of cfg_wdata as the cacheable flag and bit 3 as the prefetchable flag; the new value is seen from the cycle after the write edge.
- R3: Writes to words 0 through 15 change nothing: such a word still reads 0x0000_0000 and a lookup into its slice returns both flags low.
- R4: Read data has every bit other than 0 and 3 at zero, whatever was written.
- R5: cfg_rdata is combinational on cfg_addr and shows the stored word; a write in progress shows its effect only after the clock edge.
- R6: A lookup with lk_req high selects the word given by lk_addr[31:24]; one cycle later lk_valid is high, lk_cacheable equals stored bit 0 and lk_prefetchable equals stored bit 3, for every address from the lowest to the highest byte of the slice.
- R7: A cycle with lk_req low gives lk_valid, lk_cacheable and lk_prefetchable all low in the next cycle.
- R8: When a write and a lookup hit the same slice in the same cycle, the lookup returns the value held before the write; a lookup one cycle later returns the new value.
- R9: cfg_addr[1:0] play no part in selecting a word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all flags |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 10 | Register byte address, bits [9:2] select the word |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data for cfg_addr |
| lk_req | input | 1 | Lookup request |
| lk_addr | input | 32 | Access address to look up |
| lk_valid | output | 1 | Lookup result valid, one cycle after lk_req |
| lk_cacheable | output | 1 | Cacheable flag of the looked-up slice |
| lk_prefetchable | output | 1 | Prefetchable flag of the looked-up slice |

## Verification
A configuration write and a lookup can land on the same slice in the same cycle, and the outcome depends on whether the lookup samples the word before or after the write edge. The bench drives both strobes together on one slice holding a known value, then repeats the lookup alone on the next cycle; the first result must carry the old flags and the second the newly written ones. Protected words are written with all-ones data under the same collision to show neither path changes them.

// File: rtl/segattr_pkg.sv
package segattr_pkg;

    localparam int ADDR_W    = 32;
    localparam int SEG_W     = 8;
    localparam int NUM_SEG   = 1 << SEG_W;
    localparam int DATA_W    = 32;
    localparam int CFG_AW    = SEG_W + 2;
    localparam int CACHE_BIT = 0;
    localparam int PF_BIT    = 3;

    typedef struct packed {
        logic pf;
        logic cache;
    } attr_t;

    function automatic logic [DATA_W-1:0] attr_to_word(attr_t a);
        logic [DATA_W-1:0] w;
        w            = '0;
        w[CACHE_BIT] = a.cache;
        w[PF_BIT]    = a.pf;
        return w;
    endfunction

    function automatic attr_t word_to_attr(logic [DATA_W-1:0] w);
        attr_t a;
        a.cache = w[CACHE_BIT];
        a.pf    = w[PF_BIT];
        return a;
    endfunction

endpackage

// File: rtl/segattr_store.sv
module segattr_store
    import segattr_pkg::*;
#(
    parameter int NUM_LOCKED = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [SEG_W-1:0]      wr_idx,
    input  attr_t                 wr_attr,
    output attr_t [NUM_SEG-1:0]   seg_view
);

    localparam int NUM_WR = NUM_SEG - NUM_LOCKED;
    localparam logic [SEG_W-1:0] LOCK_LIM = SEG_W'(NUM_LOCKED);

    typedef struct packed {
        attr_t [NUM_WR-1:0] seg;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en && (wr_idx >= LOCK_LIM)) begin
            st_d.seg[wr_idx - LOCK_LIM] = wr_attr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Low segments are hardwired; the rest come from storage.
    for (genvar g = 0; g < NUM_SEG; g++) begin : g_view
        if (g < NUM_LOCKED) begin : g_fixed
            assign seg_view[g] = '0;
        end else begin : g_live
            assign seg_view[g] = st_q.seg[g - NUM_LOCKED];
        end
    end

endmodule

// File: rtl/segattr_rdmux.sv
module segattr_rdmux
    import segattr_pkg::*;
(
    input  attr_t [NUM_SEG-1:0]   seg_view,
    input  logic [SEG_W-1:0]      rd_idx,
    output logic [DATA_W-1:0]     rd_word
);

    always_comb begin
        rd_word = attr_to_word(seg_view[rd_idx]);
    end

endmodule

// File: rtl/segattr_lookup.sv
module segattr_lookup
    import segattr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  attr_t [NUM_SEG-1:0]   seg_view,
    input  logic                  req,
    input  logic [SEG_W-1:0]      seg_sel,
    output logic                  valid,
    output logic                  cacheable,
    output logic                  prefetchable
);

    typedef struct packed {
        logic valid;
        logic cache;
        logic pf;
    } state_t;

    state_t st_d, st_q;
    attr_t  hit;

    always_comb begin
        hit         = seg_view[seg_sel];
        st_d.valid  = req;
        st_d.cache  = req & hit.cache;
        st_d.pf     = req & hit.pf;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid        = st_q.valid;
    assign cacheable    = st_q.cache;
    assign prefetchable = st_q.pf;

endmodule

// File: rtl/segattr_bank.sv
module segattr_bank
    import segattr_pkg::*;
#(
    parameter int NUM_LOCKED = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CFG_AW-1:0]  cfg_addr,
    input  logic [DATA_W-1:0]  cfg_wdata,
    output logic [DATA_W-1:0]  cfg_rdata,
    input  logic               lk_req,
    input  logic [ADDR_W-1:0]  lk_addr,
    output logic               lk_valid,
    output logic               lk_cacheable,
    output logic               lk_prefetchable
);

    attr_t [NUM_SEG-1:0] seg_view;
    logic  [SEG_W-1:0]   cfg_idx;
    logic  [SEG_W-1:0]   lk_seg;
    logic                unused_bits;

    assign cfg_idx     = cfg_addr[CFG_AW-1:2];
    assign lk_seg      = lk_addr[ADDR_W-1 -: SEG_W];
    assign unused_bits = ^{cfg_addr[1:0], lk_addr[ADDR_W-SEG_W-1:0], cfg_wdata};

    segattr_store #(.NUM_LOCKED(NUM_LOCKED)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we),
        .wr_idx   (cfg_idx),
        .wr_attr  (word_to_attr(cfg_wdata)),
        .seg_view (seg_view)
    );

    segattr_rdmux u_rdmux (
        .seg_view (seg_view),
        .rd_idx   (cfg_idx),
        .rd_word  (cfg_rdata)
    );

    segattr_lookup u_lookup (
        .clk          (clk),
        .rst_n        (rst_n),
        .seg_view     (seg_view),
        .req          (lk_req),
        .seg_sel      (lk_seg),
        .valid        (lk_valid),
        .cacheable    (lk_cacheable),
        .prefetchable (lk_prefetchable)
    );

endmodule

// File: rtl/segattr_bank_chk.sv
module segattr_bank_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_we,
    input logic [9:0]  cfg_addr,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        lk_req,
    input logic [31:0] lk_addr,
    input logic        lk_valid,
    input logic        lk_cacheable,
    input logic        lk_prefetchable
);

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_rdata & ~32'h9) == 32'h0);

    a_r3_locked_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_addr[9:2] < 8'd16) |-> (cfg_rdata == 32'h0));

    a_r3_locked_lookup_zero: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req && (lk_addr[31:24] < 8'd16) |=> !lk_cacheable && !lk_prefetchable);

    a_r6_valid_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        lk_req |=> lk_valid);

    a_r7_idle_clears: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> !lk_valid && !lk_cacheable && !lk_prefetchable);

    a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_we && (cfg_addr[9:2] >= 8'd16) |=>
            (cfg_addr[9:2] != $past(cfg_addr[9:2])) ||
            (cfg_rdata == ($past(cfg_wdata) & 32'h9)));

endmodule

bind segattr_bank segattr_bank_chk u_chk (.*);

// File: tb/segattr_bank_bench.sv
module segattr_bank_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [9:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        lk_req = 1'b0;
    logic [31:0] lk_addr = '0;
    logic        lk_valid;
    logic        lk_cacheable;
    logic        lk_prefetchable;

    int checks = 0;
    int fails  = 0;
    logic [31:0] mdl [256];

    always #2 clk = ~clk;

    segattr_bank u_segattr_bank (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] expect_word(int idx, logic [31:0] d);
        return (idx < 16) ? 32'h0 : (d & 32'h9);
    endfunction

    task automatic wr(input int idx, input logic [1:0] lo, input logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_addr  = {idx[7:0], lo};
        cfg_wdata = d;
        @(negedge clk);
        cfg_we    = 1'b0;
        mdl[idx]  = expect_word(idx, d);
    endtask

    task automatic rd_chk(input string req, input int idx, input logic [1:0] lo);
        @(negedge clk);
        cfg_addr = {idx[7:0], lo};
        #1;
        chk(req, cfg_rdata, mdl[idx]);
    endtask

    task automatic lk_chk(input string req, input logic [31:0] a);
        @(negedge clk);
        lk_req  = 1'b1;
        lk_addr = a;
        @(negedge clk);
        lk_req  = 1'b0;
        chk(req, {29'h0, lk_valid, lk_prefetchable, lk_cacheable},
            {29'h0, 1'b1, mdl[a[31:24]][3], mdl[a[31:24]][0]});
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : stim
        for (int i = 0; i < 256; i++) mdl[i] = 32'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every word and lookup outputs idle
        #1;
        chk("R7 idle after reset", {31'h0, lk_valid}, 32'h0);
        for (int i = 0; i < 256; i++) rd_chk("R1 reset word", i, 2'b00);
        lk_chk("R1 reset lookup", 32'h4000_0000);

        // R2 R3 R4 R9: sweep writes with mixed data and low address bits
        for (int i = 0; i < 256; i++) begin
            logic [31:0] d;
            d = (i % 4 == 0) ? 32'hFFFF_FFFF : ((i * 32'h0101_0107) ^ 32'h5A5A_5A5A);
            wr(i, 2'(i), d);
        end
        for (int i = 0; i < 256; i++) begin
            rd_chk((i < 16) ? "R3 locked word" : "R2 R4 R9 written word", i, 2'(i + 1));
        end

        // R6: lookups at low, middle and top of each slice
        for (int i = 0; i < 256; i++) begin
            lk_chk((i < 16) ? "R3 locked lookup" : "R6 lookup low edge", {i[7:0], 24'h00_0000});
            lk_chk("R6 lookup mid", {i[7:0], 24'h7F_1234});
            lk_chk("R6 lookup top edge", {i[7:0], 24'hFF_FFFF});
        end

        // R7: no request gives idle outputs
        wr(200, 2'b00, 32'h9);
        lk_chk("R6 lookup both set", 32'hC8AB_CDEF);
        @(negedge clk);
        chk("R7 no request", {29'h0, lk_valid, lk_prefetchable, lk_cacheable}, 32'h0);

        // R5: read shows old value while a write is pending
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {8'd77, 2'b00}; cfg_wdata = ~mdl[77];
        #1;
        chk("R5 read before edge", cfg_rdata, mdl[77]);
        @(negedge clk);
        cfg_we = 1'b0;
        mdl[77] = ~mdl[77] & 32'h9;
        #1;
        chk("R5 read after edge", cfg_rdata, mdl[77]);

        // R8: write and lookup of the same slice in one cycle
        wr(40, 2'b00, 32'h8);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {8'd40, 2'b00}; cfg_wdata = 32'h1;
        lk_req = 1'b1; lk_addr = 32'h2812_3456;
        @(negedge clk);
        cfg_we = 1'b0;
        chk("R8 lookup sees old", {29'h0, lk_valid, lk_prefetchable, lk_cacheable}, 32'h6);
        mdl[40] = 32'h1;
        @(negedge clk);
        lk_req = 1'b0;
        chk("R8 next lookup sees new", {29'h0, lk_valid, lk_prefetchable, lk_cacheable}, 32'h5);

        // R3: protected write colliding with lookup
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = {8'd15, 2'b11}; cfg_wdata = 32'hFFFF_FFFF;
        lk_req = 1'b1; lk_addr = 32'h0FFF_FFFF;
        @(negedge clk);
        cfg_we = 1'b0;
        @(negedge clk);
        lk_req = 1'b0;
        chk("R3 locked after collision", {29'h0, lk_valid, lk_prefetchable, lk_cacheable}, 32'h4);
        rd_chk("R3 locked word after collision", 15, 2'b10);

        // R9: word 16 is the first writable one, reached through any low bits
        wr(16, 2'b10, 32'h9);
        rd_chk("R9 boundary word", 16, 2'b01);
        lk_chk("R2 boundary lookup", 32'h1000_0000);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule